// File: doc/BRIEF.md
# First-Order Delta-Sigma Bitstream DAC

This block converts an unsigned digital code into a one-bit pulse-density stream. A first-order loop adds the code to a running accumulator every enabled cycle. When the top bit of the accumulator is set, the loop feeds back one full-scale step. The top bit, registered once more, drives the output pin. After an external RC low-pass filter, the average level of the pin is the code divided by 2^N of the supply. A clock-enable strobe sets the update rate, so the loop can run below the clock frequency without a second clock domain.

The accumulator is N+2 bits wide. The feedback term is two copies of the accumulator top bit placed above N zero bits, which subtracts 2^N modulo 2^(N+2). When FULL_RANGE is set, the code is one bit wider, so a code of exactly 2^N drives the output to a constant 1. In that mode codes above 2^N are illegal.

Top module: `dsdac_core`

## Requirements
- R1: While rst_ni is low, the accumulator is zero and dac_o is 0. The reset is asynchronous and takes effect without a clock edge.
- R2: With a code of 0, an accumulator at zero stays at zero and dac_o stays 0.
- R3: Take a constant code c with 0 < c < 2^N and let the loop settle for 4·2^N enabled updates. Over the next 2^N enabled updates, dac_o is 1 on c±1 of them.
- R4: When en_i is low at a clock edge, the accumulator and dac_o hold their values. A change of code_i while en_i is low does not move dac_o.
- R5: On an enabled update, dac_o takes the top bit that the accumulator held before that update.
- R6: On an enabled update, the accumulator becomes old accumulator + code_i − (old top bit ? 2^N : 0), modulo 2^(N+2). The code_i used is the one present at that same edge.
- R7: With FULL_RANGE=1, code_i is N+1 bits wide. A code of 2^N gives a constant dac_o of 1 after the loop settles, and once the top bit is set it stays set.
- R8: For legal codes, the two top accumulator bits never both become 1 (no wrap of the loop state).
- R9: The count in R3 holds when en_i is high only on every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Update strobe; the loop advances only when high |
| code_i | input | N+FULL_RANGE | Unsigned input code |
| dac_o | output | 1 | Registered pulse-density output |

## Verification
The no-wrap and full-range properties assume a legal code_i: at most 2^N−1 in the normal build and at most 2^N with FULL_RANGE. The stimulus drives only codes inside those limits, including both end values. The update-equation property assumes that code_i is known at every enabled edge. The bench therefore drives code_i from time zero and holds reset until it has done so. The hold and output-register properties make no assumption about the pattern of en_i, and the stimulus uses three patterns: always on, alternating and off.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;
  function automatic int acc_width(input int n);
    return n + 2;
  endfunction
  function automatic int code_width(input int n, input int fr);
    return n + fr;
  endfunction
endpackage

// File: rtl/dsdac_delta.sv
module dsdac_delta
  import dsdac_pkg::*;
#(
  parameter int N  = 8,
  parameter int FR = 0,
  localparam int IN_W  = code_width(N, FR),
  localparam int ACC_W = acc_width(N)
) (
  input  logic [IN_W-1:0]  code_i,
  input  logic             msb_i,
  output logic [ACC_W-1:0] delta_o
);
  generate
    if (FR != 0) begin : g_full
      // code may reach 2^N and overlap the feedback bits: real adder needed
      assign delta_o = {{(ACC_W-IN_W){1'b0}}, code_i} + {msb_i, msb_i, {N{1'b0}}};
    end else begin : g_merge
      // operands never overlap: addition collapses to concatenation
      assign delta_o = {msb_i, msb_i, code_i};
    end
  endgenerate
endmodule

// File: rtl/dsdac_sigma.sv
module dsdac_sigma
  import dsdac_pkg::*;
#(
  parameter int N = 8,
  localparam int ACC_W = acc_width(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] delta_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] sum;

  assign sum = acc_o + delta_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= sum;
  end
endmodule

// File: rtl/dsdac_out.sv
module dsdac_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_o <= 1'b0;
    else if (en_i) bit_o <= bit_i;
  end
endmodule

// File: rtl/dsdac_core.sv
module dsdac_core
  import dsdac_pkg::*;
#(
  parameter int N  = 8,
  parameter int FR = 0,
  localparam int IN_W  = code_width(N, FR),
  localparam int ACC_W = acc_width(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [IN_W-1:0] code_i,
  output logic            dac_o
);
  logic [ACC_W-1:0] delta;
  logic [ACC_W-1:0] acc_q;

  dsdac_delta #(.N(N), .FR(FR)) u_delta (
    .code_i (code_i),
    .msb_i  (acc_q[ACC_W-1]),
    .delta_o(delta)
  );

  dsdac_sigma #(.N(N)) u_sigma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .delta_i(delta),
    .acc_o  (acc_q)
  );

  dsdac_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .bit_i (acc_q[ACC_W-1]),
    .bit_o (dac_o)
  );
endmodule

// File: rtl/dsdac_core_chk.sv
module dsdac_core_chk
  import dsdac_pkg::*;
#(
  parameter int N  = 8,
  parameter int FR = 0,
  localparam int IN_W  = code_width(N, FR),
  localparam int ACC_W = acc_width(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [IN_W-1:0]  code_i,
  input logic [ACC_W-1:0] acc_i,
  input logic             dac_i
);
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_expect;
  logic             code_full;

  assign step       = acc_i[ACC_W-1] ? ACC_W'(1) << N : '0;
  assign acc_expect = acc_i + ACC_W'(code_i) - step;
  assign code_full  = (FR != 0) && (ACC_W'(code_i) == (ACC_W'(1) << N));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(acc_i) && $stable(dac_i)));

  p_out_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (dac_i == $past(acc_i[ACC_W-1])));

  p_update_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (acc_i == $past(acc_expect)));

  p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_i == '0 && acc_i == '0) |=> (acc_i == '0 && !dac_i));

  p_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_full && acc_i[ACC_W-1]) |=> acc_i[ACC_W-1]);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i[ACC_W-1 -: 2] != 2'b11);
endmodule

bind dsdac_core dsdac_core_chk #(.N(N), .FR(FR)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .code_i(code_i),
  .acc_i (acc_q),
  .dac_i (dac_o)
);

// File: tb/dsdac_core_test.sv
module dsdac_core_test;
  localparam int N   = 8;
  localparam int WIN = 1 << N;

  typedef struct {
    int    sel;
    int    exp;
    int    tol;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [N-1:0] code_a = '0;
  logic [N:0]   code_b = '0;
  logic dac_a, dac_b;

  int    n_run = 0;
  int    n_fail = 0;
  int    en_mode = 2;  // 0 always, 1 alternate, 2 off
  bit    meas_on = 1'b0;
  bit    meas_done = 1'b0;
  bit    finished = 1'b0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  dsdac_core #(.N(N), .FR(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .code_i(code_a), .dac_o(dac_a));

  dsdac_core #(.N(N), .FR(1)) uut_fr (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .code_i(code_b), .dac_o(dac_b));

  // enable pattern generator
  initial begin
    forever begin
      @(negedge clk);
      #1;
      case (en_mode)
        0:       en = 1'b1;
        1:       en = ~en;
        default: en = 1'b0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    n_run++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  // monitor: count ones over WIN enabled updates, then compare with queue head
  initial begin
    int  cnt_a, cnt_b, n;
    bit  seen;
    item_t it;
    cnt_a = 0; cnt_b = 0; n = 0;
    forever begin
      @(posedge clk);
      seen = meas_on && en;
      @(negedge clk);
      if (seen && !meas_done) begin
        cnt_a += int'(dac_a);
        cnt_b += int'(dac_b);
        n++;
        if (n == WIN) begin
          it = sb_q.pop_front();
          check(it.tag, (it.sel == 0) ? cnt_a : cnt_b, it.exp, it.tol);
          cnt_a = 0; cnt_b = 0; n = 0;
          meas_done = 1'b1;
        end
      end
    end
  end

  // driver: set code, settle, push expectation, measure
  task automatic run_code(input int sel, input int code, input int mode,
                          input int exp, input int tol, input string tag);
    item_t it;
    @(negedge clk);
    if (sel == 0) code_a = N'(code);
    else          code_b = (N+1)'(code);
    en_mode = mode;
    repeat (4 * WIN * (mode == 1 ? 2 : 1) + 4) @(negedge clk);
    it.sel = sel; it.exp = exp; it.tol = tol; it.tag = tag;
    sb_q.push_back(it);
    meas_done = 1'b0;
    meas_on = 1'b1;
    wait (meas_done);
    meas_on = 1'b0;
  endtask

  initial begin
    int changes;
    logic ha, hb;
    repeat (3) @(negedge clk);
    check("R1 reset dac_o", int'(dac_a), 0, 0);
    check("R1 reset dac_o full", int'(dac_b), 0, 0);
    rst_n = 1'b1;

    run_code(0, 0,   0, 0,   0, "R2 code 0");
    run_code(0, 1,   0, 1,   1, "R3 code 1");
    run_code(0, 64,  0, 64,  1, "R3 code 64");
    run_code(0, 128, 0, 128, 1, "R3 code 128");
    run_code(0, 200, 0, 200, 1, "R3 code 200");
    run_code(0, 255, 0, 255, 1, "R3 code 255");
    run_code(0, 100, 1, 100, 1, "R9 alternate enable code 100");
    run_code(0, 0,   0, 0,   0, "R2 code 0 after nonzero");

    // R4: hold while disabled, code change ignored
    run_code(0, 128, 0, 128, 1, "R3 code 128 before hold");
    @(negedge clk);
    en_mode = 2;
    repeat (3) @(negedge clk);
    ha = dac_a; hb = dac_b;
    code_a = 8'd255; code_b = 9'd256;
    changes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dac_a != ha || dac_b != hb) changes++;
    end
    check("R4 outputs held with en_i low", changes, 0, 0);

    // R1: asynchronous reset mid-cycle
    code_a = 8'd200;
    en_mode = 0;
    for (int i = 0; i < 100 && !dac_a; i++) @(negedge clk);
    check("R1 dac_o high before reset", int'(dac_a), 1, 0);
    #2 rst_n = 1'b0;
    #1 check("R1 async reset clears dac_o", int'(dac_a), 0, 0);
    @(negedge clk);
    code_a = '0; code_b = '0;
    rst_n = 1'b1;

    run_code(1, 256, 0, WIN, 0, "R7 full range code 2^N");
    run_code(1, 0,   0, 0,   0, "R7 full range code 0");
    run_code(1, 128, 0, 128, 1, "R7 full range code 128");
    run_code(1, 255, 0, 255, 1, "R7 full range code 255");
    run_code(1, 256, 1, WIN, 0, "R7 full range 2^N alternate enable");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule